// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Threshold Request Generation

This block buffers audio samples in two 32-bit, 8-entry FIFOs. The playback FIFO is filled by bus writes and drained by the serial transmitter. The capture FIFO is filled by the serial receiver and drained by bus reads. Both FIFOs are first-word-fall-through: the oldest stored word is always visible on the output.

The block watches the fill level of each FIFO and drives three request lines: two DMA requests and one interrupt. Each line has its own configuration word. That word carries an enable and a threshold for the capture side and an enable and a threshold for the playback side. A capture threshold fires when enough words have arrived. A playback threshold fires when the FIFO has drained far enough. A line is asserted when either of its enabled sides fires.

The levels and the three request lines are also collected into one status word. The bus decoder and the serial shifters sit outside this block.

Top module: `pcm_fifo_reqgen`

## Requirements
- R1: Each FIFO holds up to 8 words of 32 bits and returns them in write order. `bus_rd_data` shows the oldest capture word and `ser_pop_data` shows the oldest playback word, in the same cycle the word becomes the oldest.
- R2: `cap_level` and `play_level` report the number of stored words (0 to 8). An accepted push or pop changes the level at the next clock edge. An accepted push together with an accepted pop leaves the level unchanged.
- R3: A push into a full FIFO (level 8) is dropped when no pop is accepted in the same cycle. The level stays at 8 and the stored words are unchanged.
- R4: A pop from an empty FIFO (level 0) leaves the level at 0. While a FIFO is empty, its data output reads zero.
- R5: A request line is asserted whenever its configuration bit 0 (capture enable) is 1 and `cap_level` is greater than or equal to the capture threshold.
- R6: A request line is asserted whenever its configuration bit 1 (playback enable) is 1 and `play_level` is less than or equal to the playback threshold.
- R7: Each request line is the OR of its own two enabled compares and nothing else. A side whose enable is 0 never contributes. The two DMA lines are independent of each other and of the interrupt line. Requests follow level and configuration changes with no register in between.
- R8: For both DMA configurations, the capture threshold is bits 12:8 and the playback threshold is bits 20:16. For the interrupt configuration, the thresholds are only 4 bits wide, at bits 11:8 and 19:16, and bits 12 and 20 are ignored.
- R9: `status_word` carries:
  - bit 0: the interrupt request
  - bit 1: DMA request 1
  - bit 2: DMA request 2
  - bits 12:8: the capture level
  - bits 20:16: the playback level
  - every other bit: zero
- R10: `rst_n` is synchronous and active low. A clock edge with `rst_n` low empties both FIFOs, so both levels read zero after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Bus write strobe into the playback FIFO |
| bus_wr_data | input | 32 | Bus write data |
| bus_rd_en | input | 1 | Bus read strobe from the capture FIFO |
| bus_rd_data | output | 32 | Oldest capture word, zero when empty |
| ser_push | input | 1 | Serial receiver push into the capture FIFO |
| ser_push_data | input | 32 | Serial receiver data |
| ser_pop | input | 1 | Serial transmitter pop from the playback FIFO |
| ser_pop_data | output | 32 | Oldest playback word, zero when empty |
| dma1_cfg | input | 32 | Configuration of DMA request 1 |
| dma2_cfg | input | 32 | Configuration of DMA request 2 |
| irq_cfg | input | 32 | Configuration of the interrupt request |
| cap_level | output | 5 | Capture FIFO fill level |
| play_level | output | 5 | Playback FIFO fill level |
| dma1_req | output | 1 | DMA request 1 |
| dma2_req | output | 1 | DMA request 2 |
| irq_req | output | 1 | Interrupt request |
| status_word | output | 32 | Packed status: requests and levels |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- **Ninth write into a full playback FIFO.** A design that lets this write through would wrap its pointer and either overwrite the oldest word or show a level of zero.
- **Read from an empty capture FIFO.** A design that decrements anyway would underflow to a level of 31, and would leak stale data on the output.
- **Opposite compare directions, tested at the exact boundary levels.** A design with a swapped or strict compare would miss a request at level equal to the threshold.
- **Interrupt configuration with bits 12 and 20 set.** A design that reads 5-bit interrupt thresholds would raise or drop the interrupt at the wrong level.
- **Simultaneous push and pop at full and at empty.** These cases separate designs that decide acceptance on the pre-edge level from designs that decide it any other way.

// File: rtl/pcm_fifo_pkg.sv
// Package: shared field positions, widths and the decoded threshold
// configuration used by the FIFO pair and its request comparators.
package pcm_fifo_pkg;

    localparam int CFG_W          = 32;
    localparam int FIELD_W        = 5;
    localparam int IRQ_MARK_W     = 4;
    localparam int CAP_EN_BIT     = 0;
    localparam int PLAY_EN_BIT    = 1;
    localparam int CAP_FIELD_LSB  = 8;
    localparam int PLAY_FIELD_LSB = 16;

    // Request line index equals its bit position in the status word.
    localparam int REQ_IRQ  = 0;
    localparam int REQ_DMA1 = 1;
    localparam int REQ_DMA2 = 2;
    localparam int NUM_REQ  = 3;

    typedef struct packed {
        logic               cap_en;
        logic               play_en;
        logic [FIELD_W-1:0] cap_mark;
        logic [FIELD_W-1:0] play_mark;
    } mark_cfg_t;

    // Pull enables and thresholds out of a raw word; thresholds keep mark_w bits.
    function automatic mark_cfg_t unpack_cfg(input logic [CFG_W-1:0] raw,
                                             input int mark_w);
        mark_cfg_t          c;
        logic [FIELD_W-1:0] keep;
        for (int i = 0; i < FIELD_W; i++) begin
            keep[i] = (i < mark_w);
        end
        c.cap_en    = raw[CAP_EN_BIT];
        c.play_en   = raw[PLAY_EN_BIT];
        c.cap_mark  = raw[CAP_FIELD_LSB +: FIELD_W] & keep;
        c.play_mark = raw[PLAY_FIELD_LSB +: FIELD_W] & keep;
        return c;
    endfunction

endpackage

// File: rtl/pcm_fifo_buf.sv
// Synchronous first-word-fall-through FIFO.
// Does: stores up to DEPTH words, shows the oldest on head_data (zero when
// empty), reports the count of stored words.
// Assumes: DEPTH >= 2; push into a full FIFO and pop from an empty FIFO are
// refused, judged on the count before the clock edge.
module pcm_fifo_buf #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic [LVL_W-1:0]  level
);

    localparam int PTR_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              full;
    logic              empty;
    logic              push_ok;
    logic              pop_ok;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Acceptance is decided on the pre-edge count only.
    always_comb begin
        full    = (level == LVL_W'(DEPTH));
        empty   = (level == '0);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
    end

    // Storage write; no reset needed because the count guards every read.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointer and count update, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Oldest word falls through; an empty FIFO reads zero.
    always_comb begin
        head_data = empty ? '0 : mem[rd_ptr];
    end

    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    a_r2_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && level < LVL_W'(DEPTH)) |=> (level == $past(level) + 1'b1));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && level == LVL_W'(DEPTH)) |=> (level == LVL_W'(DEPTH)));

    a_r3_full_keeps_head: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && level == LVL_W'(DEPTH)) |=> (head_data == $past(head_data)));

    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && level == '0) |=> (level == '0));

endmodule

// File: rtl/pcm_req_cmp.sv
// Threshold comparator for one request line.
// Does: raises req when the capture level is at or above its mark (capture
// side enabled) or the playback level is at or below its mark (playback side
// enabled).
// Assumes: LVL_W <= FIELD_W; MARK_W selects how many threshold bits count.
module pcm_req_cmp
    import pcm_fifo_pkg::*;
#(
    parameter int LVL_W  = 4,
    parameter int MARK_W = FIELD_W
) (
    input  logic [CFG_W-1:0] cfg_raw,
    input  logic [LVL_W-1:0] cap_level,
    input  logic [LVL_W-1:0] play_level,
    output logic             req
);

    mark_cfg_t          cfg;
    logic [FIELD_W-1:0] cap_l;
    logic [FIELD_W-1:0] play_l;
    logic               cap_hit;
    logic               play_hit;
    logic               unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_raw[CFG_W-1:21], cfg_raw[15:13], cfg_raw[7:2]};

    // Opposite compare directions for the filling and the draining side.
    always_comb begin
        cfg      = unpack_cfg(cfg_raw, MARK_W);
        cap_l    = FIELD_W'(cap_level);
        play_l   = FIELD_W'(play_level);
        cap_hit  = cfg.cap_en  && (cap_l  >= cfg.cap_mark);
        play_hit = cfg.play_en && (play_l <= cfg.play_mark);
        req      = cap_hit || play_hit;
    end

endmodule

// File: rtl/pcm_fifo_reqgen.sv
// Top: playback and capture FIFOs with three level-triggered request lines.
// Does: playback FIFO is written by the bus and popped by the serial side;
// capture FIFO is pushed by the serial side and read by the bus. Two DMA
// lines and one interrupt line compare both levels with their own thresholds.
// Assumes: synchronous active-low reset; requests are combinational from the
// registered levels and the configuration inputs.
module pcm_fifo_reqgen
    import pcm_fifo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr_en,
    input  logic [DATA_W-1:0]   bus_wr_data,
    input  logic                bus_rd_en,
    output logic [DATA_W-1:0]   bus_rd_data,
    input  logic                ser_push,
    input  logic [DATA_W-1:0]   ser_push_data,
    input  logic                ser_pop,
    output logic [DATA_W-1:0]   ser_pop_data,
    input  logic [CFG_W-1:0]    dma1_cfg,
    input  logic [CFG_W-1:0]    dma2_cfg,
    input  logic [CFG_W-1:0]    irq_cfg,
    output logic [FIELD_W-1:0]  cap_level,
    output logic [FIELD_W-1:0]  play_level,
    output logic                dma1_req,
    output logic                dma2_req,
    output logic                irq_req,
    output logic [CFG_W-1:0]    status_word
);

    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [LVL_W-1:0] cap_cnt;
    logic [LVL_W-1:0] play_cnt;
    logic [CFG_W-1:0] cfg_arr [NUM_REQ];
    logic [NUM_REQ-1:0] req_vec;

    // Playback path: bus writes in, serial transmitter drains.
    pcm_fifo_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_play_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (bus_wr_en),
        .push_data (bus_wr_data),
        .pop       (ser_pop),
        .head_data (ser_pop_data),
        .level     (play_cnt)
    );

    // Capture path: serial receiver fills, bus reads out.
    pcm_fifo_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_cap_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ser_push),
        .push_data (ser_push_data),
        .pop       (bus_rd_en),
        .head_data (bus_rd_data),
        .level     (cap_cnt)
    );

    // Configuration words indexed by request line.
    always_comb begin
        cfg_arr[REQ_IRQ]  = irq_cfg;
        cfg_arr[REQ_DMA1] = dma1_cfg;
        cfg_arr[REQ_DMA2] = dma2_cfg;
    end

    // One comparator per request line; the interrupt keeps narrower marks.
    for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
        localparam int MW = (g == REQ_IRQ) ? IRQ_MARK_W : FIELD_W;
        pcm_req_cmp #(.LVL_W(LVL_W), .MARK_W(MW)) u_cmp (
            .cfg_raw    (cfg_arr[g]),
            .cap_level  (cap_cnt),
            .play_level (play_cnt),
            .req        (req_vec[g])
        );
    end

    // Drive levels, request outputs and the packed status word.
    always_comb begin
        cap_level   = FIELD_W'(cap_cnt);
        play_level  = FIELD_W'(play_cnt);
        irq_req     = req_vec[REQ_IRQ];
        dma1_req    = req_vec[REQ_DMA1];
        dma2_req    = req_vec[REQ_DMA2];
        status_word = '0;
        status_word[NUM_REQ-1:0]                 = req_vec;
        status_word[CAP_FIELD_LSB +: FIELD_W]    = cap_level;
        status_word[PLAY_FIELD_LSB +: FIELD_W]   = play_level;
    end

    a_r5_cap_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (dma1_cfg[CAP_EN_BIT] && cap_level >= dma1_cfg[12:8]) |-> dma1_req);

    a_r6_play_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (dma2_cfg[PLAY_EN_BIT] && play_level <= dma2_cfg[20:16]) |-> dma2_req);

    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma1_cfg[CAP_EN_BIT] && !dma1_cfg[PLAY_EN_BIT]) |-> !dma1_req);

    a_r8_irq_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_cfg[CAP_EN_BIT] && cap_level >= {1'b0, irq_cfg[11:8]}) |-> irq_req);

endmodule

// File: tb/pcm_fifo_reqgen_bench.sv
// Bench: behavioural queue model stepped on every rising edge, compared on
// every falling edge, with directed boundary phases and a random phase.
module pcm_fifo_reqgen_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr_en, bus_rd_en, ser_push, ser_pop;
    logic [31:0] bus_wr_data, ser_push_data;
    logic [31:0] bus_rd_data, ser_pop_data;
    logic [31:0] dma1_cfg, dma2_cfg, irq_cfg;
    logic [4:0]  cap_level, play_level;
    logic        dma1_req, dma2_req, irq_req;
    logic [31:0] status_word;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    logic [31:0] play_q[$];
    logic [31:0] cap_q[$];

    pcm_fifo_reqgen u_pcm_fifo_reqgen (
        .clk(clk), .rst_n(rst_n),
        .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data),
        .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
        .ser_push(ser_push), .ser_push_data(ser_push_data),
        .ser_pop(ser_pop), .ser_pop_data(ser_pop_data),
        .dma1_cfg(dma1_cfg), .dma2_cfg(dma2_cfg), .irq_cfg(irq_cfg),
        .cap_level(cap_level), .play_level(play_level),
        .dma1_req(dma1_req), .dma2_req(dma2_req), .irq_req(irq_req),
        .status_word(status_word)
    );

    always #2 clk = ~clk;

    // Reference model: acceptance judged on the queue sizes before the edge.
    always @(posedge clk) begin
        bit pw, pr, cw, cr;
        if (!rst_n) begin
            play_q.delete();
            cap_q.delete();
        end else begin
            pw = bus_wr_en && play_q.size() < 8;
            pr = ser_pop   && play_q.size() > 0;
            cw = ser_push  && cap_q.size() < 8;
            cr = bus_rd_en && cap_q.size() > 0;
            if (pr) void'(play_q.pop_front());
            if (pw) play_q.push_back(bus_wr_data);
            if (cr) void'(cap_q.pop_front());
            if (cw) cap_q.push_back(ser_push_data);
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL R1 watchdog: cycles=%0d expected below 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    function automatic bit exp_req(input logic [31:0] cfg, input int mw,
                                   input int cl, input int pl);
        int m  = (1 << mw) - 1;
        int cm = int'((cfg >> 8) & 32'h1f) & m;
        int pm = int'((cfg >> 16) & 32'h1f) & m;
        return (cfg[0] && cl >= cm) || (cfg[1] && pl <= pm);
    endfunction

    // Compare every output against the model.
    task automatic compare_all();
        int          cl = cap_q.size();
        int          pl = play_q.size();
        bit          e_irq = exp_req(irq_cfg, 4, cl, pl);
        bit          e_d1  = exp_req(dma1_cfg, 5, cl, pl);
        bit          e_d2  = exp_req(dma2_cfg, 5, cl, pl);
        logic [31:0] e_rd  = (cl > 0) ? cap_q[0] : 32'h0;
        logic [31:0] e_tx  = (pl > 0) ? play_q[0] : 32'h0;
        logic [31:0] e_st;
        e_st = {11'h0, 5'(pl), 3'h0, 5'(cl), 5'h0, e_d2, e_d1, e_irq};
        chk(cap_level == 5'(cl), "R2 cap_level", 32'(cap_level), 32'(cl));
        chk(play_level == 5'(pl), "R2 play_level", 32'(play_level), 32'(pl));
        chk(bus_rd_data == e_rd, (cl > 0) ? "R1 bus_rd_data" : "R4 bus_rd_data empty",
            bus_rd_data, e_rd);
        chk(ser_pop_data == e_tx, (pl > 0) ? "R1 ser_pop_data" : "R4 ser_pop_data empty",
            ser_pop_data, e_tx);
        chk(dma1_req == e_d1, "R5 R6 R7 dma1_req", 32'(dma1_req), 32'(e_d1));
        chk(dma2_req == e_d2, "R5 R6 R7 dma2_req", 32'(dma2_req), 32'(e_d2));
        chk(irq_req == e_irq, "R8 irq_req", 32'(irq_req), 32'(e_irq));
        chk(status_word == e_st, "R9 status_word", status_word, e_st);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        bus_wr_en = 0; bus_rd_en = 0; ser_push = 0; ser_pop = 0;
    endtask

    function automatic logic [31:0] mk_cfg(input bit ce, input bit pe,
                                           input int cm, input int pm);
        return (32'(pm) << 16) | (32'(cm) << 8) | {30'h0, pe, ce};
    endfunction

    initial begin
        rst_n = 0; idle();
        bus_wr_data = 0; ser_push_data = 0;
        dma1_cfg = 0; dma2_cfg = 0; irq_cfg = 0;
        tick(); tick();
        chk(cap_level == 0 && play_level == 0 && status_word == 0,
            "R10 reset state", status_word, 32'h0);
        rst_n = 1;
        tick();

        // Boundary configs; irq has bits 12 and 20 set, which must be ignored (R8).
        dma1_cfg = mk_cfg(0, 1, 0, 2);
        dma2_cfg = mk_cfg(1, 0, 3, 0);
        irq_cfg  = mk_cfg(1, 1, 16 + 4, 16 + 0);
        tick();

        // Fill playback with 9 writes: the ninth is dropped (R3).
        for (int i = 0; i < 9; i++) begin
            bus_wr_en = 1; bus_wr_data = 32'hA000_0000 + 32'(i);
            tick();
        end
        idle(); tick();
        chk(play_level == 5'd8, "R3 play_level after 9 writes", 32'(play_level), 32'd8);
        chk(ser_pop_data == 32'hA000_0000, "R3 head kept at full", ser_pop_data, 32'hA000_0000);

        // Full plus simultaneous write and pop: write refused on pre-edge level.
        bus_wr_en = 1; ser_pop = 1; bus_wr_data = 32'hBEEF_0001;
        tick();
        idle();
        chk(play_level == 5'd7, "R3 full write with pop", 32'(play_level), 32'd7);

        // Read from the empty capture FIFO (R4).
        bus_rd_en = 1;
        tick();
        chk(cap_level == 0 && bus_rd_data == 0, "R4 empty read", bus_rd_data, 32'h0);
        // Empty plus push and read together: read refused, push kept.
        ser_push = 1; ser_push_data = 32'hC000_0000;
        tick();
        chk(cap_level == 5'd1, "R4 empty read with push", 32'(cap_level), 32'd1);
        idle();

        // Climb capture levels across the thresholds (R5, R8).
        for (int i = 1; i < 10; i++) begin
            ser_push = 1; ser_push_data = 32'hC000_0000 + 32'(i);
            tick();
        end
        idle();
        // Drain playback down through the threshold (R6).
        for (int i = 0; i < 9; i++) begin
            ser_pop = 1;
            tick();
        end
        idle(); tick();
        chk(dma1_req == 1'b1, "R6 dma1 at empty playback", 32'(dma1_req), 32'd1);

        // Synchronous reset with both FIFOs non-empty (R10).
        bus_wr_en = 1; bus_wr_data = 32'h1234_5678;
        tick();
        idle(); rst_n = 0;
        tick();
        chk(cap_level == 0 && play_level == 0, "R10 levels after reset",
            {cap_level, play_level}, 32'h0);
        rst_n = 1; tick();

        // Random phase.
        for (int n = 0; n < 6000; n++) begin
            if (n % 60 == 0) begin
                dma1_cfg = $urandom();
                dma2_cfg = $urandom() & 32'h001f_1f03;
                irq_cfg  = $urandom();
            end
            bus_wr_en     = ($urandom() % 100) < ((n / 500) % 2 ? 70 : 35);
            ser_pop       = ($urandom() % 100) < 45;
            ser_push      = ($urandom() % 100) < ((n / 700) % 2 ? 30 : 65);
            bus_rd_en     = ($urandom() % 100) < 45;
            bus_wr_data   = $urandom();
            ser_push_data = $urandom();
            rst_n         = ($urandom() % 1000) != 0;
            tick();
        end
        idle(); rst_n = 1; tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule